// File: doc/BRIEF.md
# Memory Boundary-Scan Test Controller

This block is the test access port of a synchronous memory die. It carries the sixteen-state test state machine driven by TMS on the rising edge of TCK. It also holds a 3-bit instruction register and three data registers, any one of which can be placed between TDI and TDO. The data registers are a one-bit bypass stage, a 32-bit identification register and a parameter-sized boundary register. The boundary register covers the bidirectional data pins, the input-only pins, a shared output-enable control cell and a set of pinless cells with fixed defaults.

On the pin side the block sits between the memory core and the pad models. Outside test, the pads carry the core's data and enable. One instruction lets the boundary register drive the bidirectional pins. Another forces every output enable off while the boundary register is scanned. The boundary register takes a parallel snapshot of the pins whenever an instruction that selects it reaches Capture-DR. Instruction changes, boundary updates and TDO changes all happen on the falling edge of TCK, so the pads and TDO only move half a cycle after the state machine does.

Top module: `mst_scan_tap`

## Requirements
- R1: A synchronous reset, and any cycle in Test-Logic-Reset, makes IDCODE (code 001) the active instruction. While IDCODE is active, the pads follow the core (io_out = core_dout, io_oe = core_oe on every pin).
- R2: Under IDCODE, Capture-DR loads ID_VALUE into the 32-bit identification register. Shift-DR then presents it on TDO least significant bit first, followed by the bits entered on TDI.
- R3: Capture-IR loads 001 into the instruction shift stage, which is shifted out least significant bit first. A shifted code becomes active only on the falling TCK edge in Update-IR; until that edge the previous instruction still governs the pads.
- R4: Codes 011, 101, 110 and 111 all select the one-bit bypass register. It loads 0 in Capture-DR, so TDO shows 0 first and then TDI delayed by one shift.
- R5: Codes 000, 010 and 100 select the boundary register. Its cells run from the TDO end as follows: NUM_IO bidirectional cells (io_in[0] first), then NUM_IN input cells (pin_in[0] first), then the output-enable control cell, then NUM_FIX pinless cells. In Capture-DR it loads the pin values, 0 into the control cell and FIX_DEFAULT into the pinless cells.
- R6: SAMPLE/PRELOAD (code 100) leaves the pads following the core. Its Update-DR falling edge copies the boundary register into the update stage.
- R7: Under EXTEST (code 000), io_out[k] is update cell k and every io_oe bit equals the control cell. Update-DR under EXTEST also refreshes the update stage.
- R8: Under SAMPLE-Z (code 010), every io_oe bit is 0 whatever core_oe is.
- R9: TDO and tdo_oe change only on falling TCK edges. tdo_oe is 1 only after a falling edge spent in Shift-IR or Shift-DR.
- R10: Five consecutive rising TCK edges with TMS high bring the state machine to Test-Logic-Reset from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset, sampled on both TCK edges |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_oe | output | 1 | Drive enable for TDO |
| pin_in | input | NUM_IN | Values seen on the input-only pins |
| io_in | input | NUM_IO | Values seen on the bidirectional data pins |
| core_dout | input | NUM_IO | Output data from the memory core |
| core_oe | input | 1 | Output enable from the memory core |
| io_out | output | NUM_IO | Data driven to the bidirectional pads |
| io_oe | output | NUM_IO | Per-pad drive enable |

## Verification
The bench walks all eight instruction codes in turn. For each, it sets a different pin pattern and a different 48-bit TDI stream, then compares the whole TDO stream with a stream built from the requirements. The length of the leading captured section separates the three register lengths (1, 32 and 10 bits). Its content separates a pin snapshot, the identification value and a lone zero. A separate preload/EXTEST sequence samples the pads on both sides of the Update-IR falling edge, which shows that the drive starts at that edge and not earlier. TMS-only and reset-only escapes from a non-default instruction are each followed by an identification read.

// File: rtl/mst_pkg.sv
package mst_pkg;

  typedef enum logic [3:0] {
    ST_TLR    = 4'd0,
    ST_RTI    = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SHF_DR = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PAU_DR = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SHF_IR = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PAU_IR = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_state_e;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] INS_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] INS_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] INS_SAMPZ   = 3'b010;
  localparam logic [IR_W-1:0] INS_PRELOAD = 3'b100;
  localparam logic [IR_W-1:0] INS_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;

  typedef struct packed {
    logic sel_bsr;
    logic sel_id;
    logic sel_byp;
    logic drive_pins;
    logic force_hiz;
    logic upd_en;
  } ins_ctl_t;

  function automatic ins_ctl_t decode_ins(input logic [IR_W-1:0] code);
    ins_ctl_t c;
    c = '0;
    unique case (code)
      INS_EXTEST: begin
        c.sel_bsr    = 1'b1;
        c.drive_pins = 1'b1;
        c.upd_en     = 1'b1;
      end
      INS_IDCODE: c.sel_id = 1'b1;
      INS_SAMPZ: begin
        c.sel_bsr   = 1'b1;
        c.force_hiz = 1'b1;
      end
      INS_PRELOAD: begin
        c.sel_bsr = 1'b1;
        c.upd_en  = 1'b1;
      end
      default: c.sel_byp = 1'b1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mst_tap_fsm.sv
module mst_tap_fsm
  import mst_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state_q
);

  tap_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state_q <= ST_TLR;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/mst_ir_unit.sv
module mst_ir_unit
  import mst_pkg::*;
(
  input  logic            tck,
  input  logic            rst,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_shift,
  output logic [IR_W-1:0] ir_active
);

  // Shift stage works on the rising edge.
  always_ff @(posedge tck) begin
    if (rst) begin
      ir_shift <= IR_CAPTURE;
    end else if (state == ST_CAP_IR) begin
      ir_shift <= IR_CAPTURE;
    end else if (state == ST_SHF_IR) begin
      ir_shift <= {tdi, ir_shift[IR_W-1:1]};
    end
  end

  // Active instruction changes only on the falling edge.
  always_ff @(negedge tck) begin
    if (rst || state == ST_TLR) begin
      ir_active <= INS_IDCODE;
    end else if (state == ST_UPD_IR) begin
      ir_active <= ir_shift;
    end
  end

endmodule

// File: rtl/mst_dr_unit.sv
module mst_dr_unit
  import mst_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_IO  = 8,
  parameter int NUM_FIX = 2,
  parameter logic [NUM_FIX-1:0] FIX_DEFAULT = '0,
  parameter logic [ID_W-1:0]    ID_VALUE    = 32'h1A5B_3C71,
  localparam int BSR_LEN = NUM_IO + NUM_IN + 1 + NUM_FIX
)(
  input  logic               tck,
  input  logic               rst,
  input  logic               tdi,
  input  tap_state_e         state,
  input  ins_ctl_t           ctl,
  input  logic [NUM_IN-1:0]  pin_in,
  input  logic [NUM_IO-1:0]  io_in,
  output logic               dr_tdo,
  output logic [BSR_LEN-1:0] upd_q,
  output logic               byp_q,
  output logic [ID_W-1:0]    id_q
);

  localparam int IN_BASE  = NUM_IO;
  localparam int OE_CELL  = NUM_IO + NUM_IN;
  localparam int FIX_BASE = OE_CELL + 1;

  logic [BSR_LEN-1:0] bsr_q;
  logic [BSR_LEN-1:0] cap_vec;

  // Parallel snapshot, laid out from the TDO end.
  always_comb begin
    cap_vec = '0;
    for (int k = 0; k < NUM_IO; k++)  cap_vec[k]            = io_in[k];
    for (int k = 0; k < NUM_IN; k++)  cap_vec[IN_BASE + k]  = pin_in[k];
    cap_vec[OE_CELL] = 1'b0;
    for (int k = 0; k < NUM_FIX; k++) cap_vec[FIX_BASE + k] = FIX_DEFAULT[k];
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      bsr_q <= '0;
    end else if (ctl.sel_bsr) begin
      if (state == ST_CAP_DR)      bsr_q <= cap_vec;
      else if (state == ST_SHF_DR) bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      id_q <= '0;
    end else if (ctl.sel_id) begin
      if (state == ST_CAP_DR)      id_q <= ID_VALUE;
      else if (state == ST_SHF_DR) id_q <= {tdi, id_q[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      byp_q <= 1'b0;
    end else if (ctl.sel_byp) begin
      if (state == ST_CAP_DR)      byp_q <= 1'b0;
      else if (state == ST_SHF_DR) byp_q <= tdi;
    end
  end

  // Update stage: falling edge in Update-DR.
  always_ff @(negedge tck) begin
    if (rst) begin
      upd_q <= '0;
    end else if (state == ST_UPD_DR && ctl.upd_en) begin
      upd_q <= bsr_q;
    end
  end

  always_comb begin
    if (ctl.sel_bsr)     dr_tdo = bsr_q[0];
    else if (ctl.sel_id) dr_tdo = id_q[0];
    else                 dr_tdo = byp_q;
  end

endmodule

// File: rtl/mst_pad_mux.sv
module mst_pad_mux
  import mst_pkg::*;
#(
  parameter int NUM_IO = 8
)(
  input  ins_ctl_t          ctl,
  input  logic [NUM_IO-1:0] upd_data,
  input  logic              upd_oe,
  input  logic [NUM_IO-1:0] core_dout,
  input  logic              core_oe,
  output logic [NUM_IO-1:0] io_out,
  output logic [NUM_IO-1:0] io_oe
);

  for (genvar k = 0; k < NUM_IO; k++) begin : g_pad
    always_comb begin
      if (ctl.drive_pins) begin
        io_out[k] = upd_data[k];
        io_oe[k]  = upd_oe;
      end else begin
        io_out[k] = core_dout[k];
        io_oe[k]  = core_oe & ~ctl.force_hiz;
      end
    end
  end

endmodule

// File: rtl/mst_scan_tap.sv
module mst_scan_tap
  import mst_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_IO  = 8,
  parameter int NUM_FIX = 2,
  parameter logic [NUM_FIX-1:0] FIX_DEFAULT = '0,
  parameter logic [31:0]        ID_VALUE    = 32'h1A5B_3C71
)(
  input  logic              tck,
  input  logic              rst,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  input  logic [NUM_IN-1:0] pin_in,
  input  logic [NUM_IO-1:0] io_in,
  input  logic [NUM_IO-1:0] core_dout,
  input  logic              core_oe,
  output logic [NUM_IO-1:0] io_out,
  output logic [NUM_IO-1:0] io_oe
);

  localparam int BSR_LEN = NUM_IO + NUM_IN + 1 + NUM_FIX;
  localparam int OE_CELL = NUM_IO + NUM_IN;

  tap_state_e         state_q;
  logic [IR_W-1:0]    ir_shift;
  logic [IR_W-1:0]    ir_active;
  ins_ctl_t           ctl;
  logic               dr_tdo;
  logic [BSR_LEN-1:0] upd_q;
  logic               byp_q;
  logic [ID_W-1:0]    id_q;

  mst_tap_fsm u_fsm (
    .tck     (tck),
    .rst     (rst),
    .tms     (tms),
    .state_q (state_q)
  );

  mst_ir_unit u_ir (
    .tck       (tck),
    .rst       (rst),
    .tdi       (tdi),
    .state     (state_q),
    .ir_shift  (ir_shift),
    .ir_active (ir_active)
  );

  assign ctl = decode_ins(ir_active);

  mst_dr_unit #(
    .NUM_IN      (NUM_IN),
    .NUM_IO      (NUM_IO),
    .NUM_FIX     (NUM_FIX),
    .FIX_DEFAULT (FIX_DEFAULT),
    .ID_VALUE    (ID_VALUE)
  ) u_dr (
    .tck    (tck),
    .rst    (rst),
    .tdi    (tdi),
    .state  (state_q),
    .ctl    (ctl),
    .pin_in (pin_in),
    .io_in  (io_in),
    .dr_tdo (dr_tdo),
    .upd_q  (upd_q),
    .byp_q  (byp_q),
    .id_q   (id_q)
  );

  mst_pad_mux #(
    .NUM_IO (NUM_IO)
  ) u_pad (
    .ctl       (ctl),
    .upd_data  (upd_q[NUM_IO-1:0]),
    .upd_oe    (upd_q[OE_CELL]),
    .core_dout (core_dout),
    .core_oe   (core_oe),
    .io_out    (io_out),
    .io_oe     (io_oe)
  );

  // Serial output: falling edge, enabled only in the shift states.
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SHF_IR: begin
          tdo    <= ir_shift[0];
          tdo_oe <= 1'b1;
        end
        ST_SHF_DR: begin
          tdo    <= dr_tdo;
          tdo_oe <= 1'b1;
        end
        default: tdo_oe <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/mst_scan_tap_chk.sv
module mst_scan_tap_chk
  import mst_pkg::*;
#(
  parameter int          NUM_IO   = 8,
  parameter logic [31:0] ID_VALUE = 32'h1A5B_3C71
)(
  input logic              tck,
  input logic              rst,
  input logic              tms,
  input tap_state_e        state,
  input logic [IR_W-1:0]   ir_act,
  input logic [IR_W-1:0]   ir_sh,
  input logic              byp_sel,
  input logic              byp_q,
  input logic              id_sel,
  input logic [ID_W-1:0]   id_q,
  input logic [NUM_IO-1:0] io_oe,
  input logic              tdo_oe
);

  logic [2:0] high_cnt;

  always_ff @(posedge tck) begin
    if (rst)           high_cnt <= '0;
    else if (!tms)     high_cnt <= '0;
    else if (high_cnt != 3'd5) high_cnt <= high_cnt + 3'd1;
  end

  assert_idcode_in_reset_R1: assert property (@(posedge tck) disable iff (rst)
    state == ST_TLR |-> ir_act == INS_IDCODE);

  assert_id_capture_R2: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_DR && id_sel) |=> id_q == ID_VALUE);

  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (rst)
    state == ST_CAP_IR |=> ir_sh == IR_CAPTURE);

  assert_bypass_zero_R4: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_DR && byp_sel) |=> byp_q == 1'b0);

  assert_samplez_hiz_R8: assert property (@(posedge tck) disable iff (rst)
    ir_act == INS_SAMPZ |-> io_oe == '0);

  assert_tdo_window_R9: assert property (@(posedge tck) disable iff (rst)
    tdo_oe |-> (state == ST_SHF_IR || state == ST_SHF_DR));

  assert_tms_reset_R10: assert property (@(posedge tck) disable iff (rst)
    high_cnt == 3'd5 |-> state == ST_TLR);

endmodule

bind mst_scan_tap mst_scan_tap_chk #(
  .NUM_IO   (NUM_IO),
  .ID_VALUE (ID_VALUE)
) u_chk (
  .tck     (tck),
  .rst     (rst),
  .tms     (tms),
  .state   (state_q),
  .ir_act  (ir_active),
  .ir_sh   (ir_shift),
  .byp_sel (ctl.sel_byp),
  .byp_q   (byp_q),
  .id_sel  (ctl.sel_id),
  .id_q    (id_q),
  .io_oe   (io_oe),
  .tdo_oe  (tdo_oe)
);

// File: tb/mst_scan_tap_bench.sv
module mst_scan_tap_bench;

  localparam int NI  = 3;
  localparam int NO  = 4;
  localparam int NF  = 2;
  localparam int L   = NO + NI + 1 + NF;
  localparam int OEC = NO + NI;
  localparam logic [NF-1:0] FIXD = 2'b10;
  localparam logic [31:0]   IDV  = 32'h2B6D_90E5;
  localparam int NSH = 48;

  logic          tck = 1'b0;
  logic          rst = 1'b1;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic          tdo;
  logic          tdo_oe;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] io_in = '0;
  logic [NO-1:0] core_dout = 4'b0110;
  logic          core_oe = 1'b1;
  logic [NO-1:0] io_out;
  logic [NO-1:0] io_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 tck = ~tck;

  mst_scan_tap #(
    .NUM_IN(NI), .NUM_IO(NO), .NUM_FIX(NF), .FIX_DEFAULT(FIXD), .ID_VALUE(IDV)
  ) u_mst_scan_tap (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .io_in(io_in), .core_dout(core_dout), .core_oe(core_oe),
    .io_out(io_out), .io_oe(io_oe)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at rising edge + 1; samples TDO after the falling edge.
  task automatic step(input logic m, input logic d, output logic o);
    #2;
    o   = tdo;
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  task automatic shift_bits(input int n, input logic [63:0] din,
                            output logic [63:0] dout);
    logic b;
    dout = '0;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], b);
      dout[i] = b;
    end
  endtask

  task automatic to_update_then_idle();
    logic b;
    step(1'b1, 1'b0, b);
    step(1'b0, 1'b0, b);
  endtask

  task automatic to_shift_dr();
    logic b;
    step(1'b1, 1'b0, b);
    step(1'b0, 1'b0, b);
    step(1'b0, 1'b0, b);
  endtask

  task automatic to_shift_ir();
    logic b;
    step(1'b1, 1'b0, b);
    step(1'b1, 1'b0, b);
    step(1'b0, 1'b0, b);
    step(1'b0, 1'b0, b);
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] capt);
    logic [63:0] o;
    to_shift_ir();
    shift_bits(3, {61'd0, code}, o);
    capt = o[2:0];
    to_update_then_idle();
  endtask

  task automatic read_id(input string req);
    logic [63:0] o;
    to_shift_dr();
    shift_bits(32, 64'd0, o);
    to_update_then_idle();
    check(o[31:0] == IDV, req, {32'd0, o[31:0]}, {32'd0, IDV});
  endtask

  task automatic pads_follow_core(input string req);
    check(io_out == core_dout && io_oe == {NO{core_oe}}, req,
          {56'd0, io_oe, io_out}, {56'd0, {NO{core_oe}}, core_dout});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge tck);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic        b;
    logic [2:0]  capt;
    logic [63:0] pat, o, ex;
    logic [L-1:0] cap, pre;
    logic [NO-1:0] eo;

    repeat (3) @(posedge tck);
    #1;
    rst = 1'b0;
    // R1 / R9: reset state.
    check(tdo_oe == 1'b0, "R9 tdo_oe after reset", {63'd0, tdo_oe}, 64'd0);
    pads_follow_core("R1 pads after reset");
    step(1'b0, 1'b0, b);

    // R9: enable changes only at falling edge; R2 ID read.
    step(1'b1, 1'b0, b);
    step(1'b0, 1'b0, b);
    step(1'b0, 1'b0, b);
    check(tdo_oe == 1'b0, "R9 tdo_oe before falling edge", {63'd0, tdo_oe}, 64'd0);
    #2;
    check(tdo_oe == 1'b1 && tdo == IDV[0], "R9 tdo after falling edge",
          {62'd0, tdo_oe, tdo}, {62'd0, 1'b1, IDV[0]});
    #0;
    tms = 1'b0;
    @(posedge tck);
    #1;
    shift_bits(31, 64'd0, o);
    check(o[30:0] == IDV[31:1], "R2 identification after reset",
          {33'd0, o[30:0]}, {33'd0, IDV[31:1]});
    to_update_then_idle();
    check(tdo_oe == 1'b0, "R9 tdo_oe idle", {63'd0, tdo_oe}, 64'd0);

    // Sweep of all instruction codes.
    for (int c = 0; c < 8; c++) begin
      io_in  = NO'(c * 3 + 5);
      pin_in = NI'(c ^ 5);
      load_ir(3'(c), capt);
      check(capt == 3'b001, "R3 instruction capture", {61'd0, capt}, 64'd1);
      pat = 64'hA5C3_96F0_1E2D_7B48 ^ (64'(c) * 64'h1357_9BDF_2468);
      to_shift_dr();
      shift_bits(NSH, pat, o);
      to_update_then_idle();
      for (int j = 0; j < NO; j++) cap[j] = io_in[j];
      for (int j = 0; j < NI; j++) cap[NO + j] = pin_in[j];
      cap[OEC] = 1'b0;
      for (int j = 0; j < NF; j++) cap[OEC + 1 + j] = FIXD[j];
      ex = '0;
      for (int i = 0; i < NSH; i++) begin
        if (c == 0 || c == 2 || c == 4) ex[i] = (i < L) ? cap[i] : pat[i - L];
        else if (c == 1)                ex[i] = (i < 32) ? IDV[i] : pat[i - 32];
        else                            ex[i] = (i == 0) ? 1'b0 : pat[i - 1];
      end
      if (c == 0 || c == 2 || c == 4)
        check(o == ex, $sformatf("R5 boundary stream code %0d", c), o, ex);
      else if (c == 1)
        check(o == ex, "R2 identification stream", o, ex);
      else
        check(o == ex, $sformatf("R4 bypass stream code %0d", c), o, ex);
      if (c == 0) begin
        for (int j = 0; j < NO; j++) eo[j] = pat[NSH - L + j];
        check(io_out == eo && io_oe == {NO{pat[NSH - L + OEC]}}, "R7 extest drive",
              {56'd0, io_oe, io_out}, {56'd0, {NO{pat[NSH - L + OEC]}}, eo});
      end else if (c == 2) begin
        check(io_oe == '0, "R8 sample-z enables off", {60'd0, io_oe}, 64'd0);
      end else if (c == 4) begin
        pads_follow_core("R6 preload keeps core on pads");
      end else begin
        pads_follow_core("R1 pads follow core");
      end
    end

    // R6/R7/R3: preload then EXTEST with Update-IR edge timing.
    pre = 10'b1_0_1_011_1001;
    load_ir(3'b100, capt);
    to_shift_dr();
    shift_bits(L, {54'd0, pre}, o);
    to_update_then_idle();
    pads_follow_core("R6 pads after preload update");
    to_shift_ir();
    shift_bits(3, 64'd0, o);
    step(1'b1, 1'b0, b);
    pads_follow_core("R3 before Update-IR falling edge");
    #2;
    check(io_out == pre[NO-1:0] && io_oe == {NO{pre[OEC]}}, "R7 drive from falling edge",
          {56'd0, io_oe, io_out}, {56'd0, {NO{pre[OEC]}}, pre[NO-1:0]});
    tms = 1'b0;
    @(posedge tck);
    #1;

    // R10: five TMS-high edges from Shift-DR.
    load_ir(3'b111, capt);
    to_shift_dr();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, b);
    #2;
    pads_follow_core("R10 reset by tms restores idcode");
    tms = 1'b0;
    @(posedge tck);
    #1;
    read_id("R10 identification after tms reset");

    // R1: synchronous reset from a non-default instruction.
    load_ir(3'b010, capt);
    check(io_oe == '0, "R8 sample-z with core enabled", {60'd0, io_oe}, 64'd0);
    rst = 1'b1;
    repeat (2) @(posedge tck);
    #1;
    rst = 1'b0;
    #2;
    pads_follow_core("R1 pads after mid-run reset");
    tms = 1'b0;
    @(posedge tck);
    #1;
    read_id("R1 identification after mid-run reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule